// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block sits on the receive side of a register-mapped CEC controller. A bit-level receiver hands it completed frames: a header byte, an optional opcode, up to fourteen operand bytes, an operand count and a line-error flag. The low nibble of the header is the destination address. The block checks that address against a 16-bit mask of claimed logical addresses. It queues frames that pass in a small frame FIFO.

Host software sees the oldest queued frame through a simple byte-wide register port. One status byte gives the queue depth, the head frame's error flag and its operand count. The header, opcode and operands have their own read addresses, with the operands four bytes apart. Self-clearing control bits drop the head frame or empty the whole queue. A sticky flag, cleared by writing one, raises an interrupt whenever a frame is queued.

Top module: `cec_rx_fifo`

Register offsets (byte addresses): 0x00 status (read-only), 0x04 control, 0x08 event flags, 0x0C mask for addresses 0–7, 0x10 mask for addresses 8–15, 0x14 head header, 0x18 head opcode, 0x20 + 4·i head operand i (i = 0..13). Any other address reads 0.

## Requirements
- R1: An incoming frame is queued only if bit d of the 16-bit address mask is set, where d is header bits 3:0. With the mask at zero, no frame is queued.
- R2: Mask bit n for addresses 0–7 is bit n of offset 0x0C. Mask bit n for addresses 8–15 is bit n-8 of offset 0x10. Both read back what was written.
- R3: The queue holds 4 frames. A frame that arrives while 4 are queued is discarded, and the queued frames are left unchanged.
- R4: The status byte at 0x00 has three fields. Bits 6:4 hold the number of queued frames. Bit 7 holds the head frame's error flag. Bits 3:0 hold the head frame's operand count. The byte reads 0x00 when the queue is empty.
- R5: The head registers show the oldest frame first (arrival order): header at 0x14, opcode at 0x18, operand i at 0x20+4·i. An operand index at or beyond the operand count reads 0, and every head register reads 0 when the queue is empty.
- R6: A frame with no opcode (frm_has_op_i = 0) is stored with an operand count of 0, and its opcode register reads 0.
- R7: A frame flagged with a line error is still queued, and its status bit 7 reads 1 while it is at the head.
- R8: Writing 1 to control bit 0 drops the head frame. Bit 0 reads 1 for the cycle after the write, then returns to 0 once the frame is gone. On an empty queue the write has no effect on the status byte.
- R9: Writing 0x3 to control empties the whole queue. Control bits 1:0 read 0x3 for the cycle after the write, then 0 with the status byte at 0x00.
- R10: Event flag bit 1 at 0x08 is set each time a frame is queued, and irq_o follows it. Writing 1 to that bit clears it, but a frame queued in the same cycle keeps it set.
- R11: An operand count above 14 is clamped to 14.
- R12: After reset the queue is empty, the mask is zero, the control and event bits are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | One-cycle strobe: a completed frame is present |
| frm_hdr_i | input | 8 | Header byte; bits 3:0 are the destination |
| frm_has_op_i | input | 1 | Frame carries an opcode |
| frm_opc_i | input | 8 | Opcode byte |
| frm_len_i | input | 4 | Number of operand bytes |
| frm_opnd_i | input | 112 | Operand i at bits 8i+7:8i |
| frm_err_i | input | 1 | Line error seen while receiving the frame |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Frame-queued interrupt flag |

## Verification
The bench fills the queue through destinations that are claimed, unclaimed and broadcast, then sends one more frame into a full queue. A design that overwrote the oldest entry or miscounted would show the wrong header or depth when the queue drains. Header-only frames, error frames and frames whose operand count is too large are read back operand by operand. This catches a design that exposes stale bytes, fails to clamp, or leaks an opcode into a header-only frame. The drop and flush bits are read back in the cycle after the write and again one cycle later. A design that cleared them too soon, never cleared them, or popped an empty queue shows up there. The bench also writes the flag clear in the same cycle as an incoming frame, which catches a clear that wins over the set.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int OPND_MAX = 14;
  localparam int LEN_W    = 4;

  localparam int OFF_STAT    = 'h00;
  localparam int OFF_CTRL    = 'h04;
  localparam int OFF_EVT     = 'h08;
  localparam int OFF_MASK_LO = 'h0C;
  localparam int OFF_MASK_HI = 'h10;
  localparam int OFF_HDR     = 'h14;
  localparam int OFF_OPC     = 'h18;
  localparam int OFF_OPND    = 'h20;

  typedef struct packed {
    logic                     err;
    logic                     has_op;
    logic [LEN_W-1:0]         len;
    logic [7:0]               hdr;
    logic [7:0]               opc;
    logic [OPND_MAX-1:0][7:0] opnd;
  } frame_t;
endpackage

// File: rtl/cec_rx_filter.sv
module cec_rx_filter (
  input  logic        valid_i,
  input  logic [3:0]  dest_i,
  input  logic [15:0] mask_i,
  output logic        accept_o
);
  assign accept_o = valid_i & mask_i[dest_i];
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store import cec_rx_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  frame_t             frame_i,
  input  logic               pop_i,
  input  logic               flush_i,
  output frame_t             head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic               pushed_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t             mem [DEPTH];
  logic [PTR_W-1:0]   wr_q, rd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               do_pop, do_push;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop   = pop_i && (cnt_q != '0);
  // a pop in the same cycle frees the slot a full queue needs
  assign do_push  = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
  assign pushed_o = do_push && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (pushed_o) mem[wr_q] <= frame_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/cec_rx_regs.sv
module cec_rx_regs import cec_rx_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  frame_t             head_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic               pushed_i,
  output logic [15:0]        mask_o,
  output logic               pop_o,
  output logic               flush_o,
  output logic               irq_o
);
  logic [15:0] mask_q;
  logic [1:0]  ctrl_q;
  logic        ne_q;
  logic        empty;
  logic        wr_ctrl, wr_evt;

  assign empty   = (count_i == '0);
  assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_evt  = we_i && (addr_i == ADDR_W'(OFF_EVT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ctrl_q <= '0;
      ne_q   <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_W'(OFF_MASK_LO)) mask_q[7:0]  <= wdata_i;
      if (we_i && addr_i == ADDR_W'(OFF_MASK_HI)) mask_q[15:8] <= wdata_i;
      // command bits live one cycle: the action completes at the next edge
      ctrl_q <= wr_ctrl ? wdata_i[1:0] : 2'b00;
      ne_q   <= pushed_i | (ne_q & ~(wr_evt & wdata_i[1]));
    end
  end

  assign mask_o  = mask_q;
  assign pop_o   = ctrl_q[0] & ~ctrl_q[1];
  assign flush_o = ctrl_q[1];
  assign irq_o   = ne_q;

  always_comb begin
    rdata_o = 8'h00;
    unique case (addr_i)
      ADDR_W'(OFF_STAT):    rdata_o = empty ? 8'h00 : {head_i.err, 3'(count_i), head_i.len};
      ADDR_W'(OFF_CTRL):    rdata_o = {6'b0, ctrl_q};
      ADDR_W'(OFF_EVT):     rdata_o = {6'b0, ne_q, 1'b0};
      ADDR_W'(OFF_MASK_LO): rdata_o = mask_q[7:0];
      ADDR_W'(OFF_MASK_HI): rdata_o = mask_q[15:8];
      ADDR_W'(OFF_HDR):     rdata_o = empty ? 8'h00 : head_i.hdr;
      ADDR_W'(OFF_OPC):     rdata_o = (empty || !head_i.has_op) ? 8'h00 : head_i.opc;
      default: begin
        for (int i = 0; i < OPND_MAX; i++) begin
          if (addr_i == ADDR_W'(OFF_OPND + 4*i) && !empty && (LEN_W'(i) < head_i.len))
            rdata_o = head_i.opnd[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/cec_rx_fifo.sv
module cec_rx_fifo import cec_rx_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frm_valid_i,
  input  logic [7:0]            frm_hdr_i,
  input  logic                  frm_has_op_i,
  input  logic [7:0]            frm_opc_i,
  input  logic [3:0]            frm_len_i,
  input  logic [OPND_MAX*8-1:0] frm_opnd_i,
  input  logic                  frm_err_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  output logic                  irq_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [15:0]      mask;
  logic             accept, pop, flush, pushed;
  logic [CNT_W-1:0] count;
  frame_t           in_frame, head;

  always_comb begin
    in_frame.err    = frm_err_i;
    in_frame.has_op = frm_has_op_i;
    in_frame.hdr    = frm_hdr_i;
    in_frame.opc    = frm_has_op_i ? frm_opc_i : 8'h00;
    in_frame.opnd   = frm_opnd_i;
    if (!frm_has_op_i)                   in_frame.len = '0;
    else if (frm_len_i > LEN_W'(OPND_MAX)) in_frame.len = LEN_W'(OPND_MAX);
    else                                 in_frame.len = frm_len_i;
  end

  cec_rx_filter i_filter (
    .valid_i  (frm_valid_i),
    .dest_i   (frm_hdr_i[3:0]),
    .mask_i   (mask),
    .accept_o (accept)
  );

  cec_rx_store #(.DEPTH(DEPTH)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (accept),
    .frame_i  (in_frame),
    .pop_i    (pop),
    .flush_i  (flush),
    .head_o   (head),
    .count_o  (count),
    .pushed_o (pushed)
  );

  cec_rx_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .head_i   (head),
    .count_i  (count),
    .pushed_i (pushed),
    .mask_o   (mask),
    .pop_o    (pop),
    .flush_o  (flush),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/cec_rx_fifo_chk.sv
module cec_rx_fifo_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       frm_valid_i,
  input logic [7:0]                 frm_hdr_i,
  input logic [15:0]                mask_i,
  input logic [$clog2(DEPTH+1)-1:0] count_i,
  input logic                       pop_i,
  input logic                       flush_i,
  input logic                       irq_o,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [7:0]                 reg_rdata_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic claimed;
  assign claimed = mask_i[frm_hdr_i[3:0]];

  a_r1_unclaimed_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && !claimed && !pop_i && !flush_i |=> count_i == $past(count_i));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == CNT_W'(DEPTH) && !pop_i && !flush_i |=> count_i == CNT_W'(DEPTH));

  a_r4_empty_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == '0 && count_i == '0 |-> reg_rdata_o == 8'h00);

  a_r8_drop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !flush_i && count_i != '0 && !frm_valid_i |=> count_i == CNT_W'($past(count_i) - 1'b1));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_i == '0);

  a_r10_flag_on_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && claimed && !flush_i && count_i < CNT_W'(DEPTH) |=> irq_o);
endmodule

bind cec_rx_fifo cec_rx_fifo_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_valid_i (frm_valid_i),
  .frm_hdr_i   (frm_hdr_i),
  .mask_i      (mask),
  .count_i     (count),
  .pop_i       (pop),
  .flush_i     (flush),
  .irq_o       (irq_o),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/test_cec_rx_fifo.sv
`timescale 1ns/1ps
module test_cec_rx_fifo;
  localparam int NOP = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frm_valid = 1'b0;
  logic [7:0]     frm_hdr = '0;
  logic           frm_has_op = 1'b0;
  logic [7:0]     frm_opc = '0;
  logic [3:0]     frm_len = '0;
  logic [NOP*8-1:0] frm_opnd = '0;
  logic           frm_err = 1'b0;
  logic           we = 1'b0;
  logic [7:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic           irq;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] hdr;
    logic [7:0] opc;
    logic       err;
    logic [3:0] len;
    logic [7:0] seed;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] mask_m = '0;

  always #10 clk = ~clk;

  cec_rx_fifo i_cec_rx_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .frm_valid_i(frm_valid), .frm_hdr_i(frm_hdr), .frm_has_op_i(frm_has_op),
    .frm_opc_i(frm_opc), .frm_len_i(frm_len), .frm_opnd_i(frm_opnd), .frm_err_i(frm_err),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq)
  );

  function automatic logic [7:0] opnd_val(logic [7:0] seed, int i);
    return seed + 8'(i * 17);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: drives a frame and records the expected queue entry
  task automatic drive_frame(logic [7:0] h, logic op, logic [7:0] oc, logic [3:0] ln,
                             logic e, logic [7:0] seed);
    exp_t x;
    frm_hdr = h; frm_has_op = op; frm_opc = oc; frm_len = ln; frm_err = e;
    for (int i = 0; i < NOP; i++) frm_opnd[i*8 +: 8] = opnd_val(seed, i);
    frm_valid = 1'b1;
    if (mask_m[h[3:0]] && sb.size() < 4) begin
      x.hdr = h; x.err = e; x.seed = seed;
      x.opc = op ? oc : 8'h00;
      x.len = !op ? 4'd0 : (ln > 4'd14 ? 4'd14 : ln);
      sb.push_back(x);
    end
  endtask

  task automatic send(logic [7:0] h, logic op, logic [7:0] oc, logic [3:0] ln,
                      logic e, logic [7:0] seed);
    @(negedge clk);
    drive_frame(h, op, oc, ln, e, seed);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // monitor: compares the head frame with the scoreboard front, then drops it
  task automatic check_head(string tag);
    exp_t x;
    logic [7:0] d;
    x = sb.pop_front();
    rd(8'h00, d); chk({tag, " R4 status"}, d, {x.err, 3'(sb.size() + 1), x.len});
    rd(8'h14, d); chk({tag, " R5 header"}, d, x.hdr);
    rd(8'h18, d); chk({tag, " R6 opcode"}, d, x.opc);
    for (int i = 0; i < NOP; i++) begin
      rd(8'(8'h20 + 4*i), d);
      chk({tag, " R5 operand"}, d, (i < int'(x.len)) ? opnd_val(x.seed, i) : 8'h00);
    end
    wr(8'h04, 8'h01);
    rd(8'h04, d); chk({tag, " R8 drop bit pending"}, d, 8'h01);
    @(negedge clk);
    rd(8'h04, d); chk({tag, " R8 drop bit cleared"}, d, 8'h00);
    rd(8'h00, d); chk({tag, " R8 depth after drop"}, d[6:4], 8'(sb.size()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(8'h00, d); chk("R12 status", d, 8'h00);
    rd(8'h0C, d); chk("R12 mask lo", d, 8'h00);
    rd(8'h10, d); chk("R12 mask hi", d, 8'h00);
    rd(8'h04, d); chk("R12 ctrl", d, 8'h00);
    rd(8'h08, d); chk("R12 event", d, 8'h00);
    chk("R12 irq", {7'b0, irq}, 8'h00);

    // R1 zero mask accepts nothing
    send(8'h04, 1'b1, 8'h36, 4'd2, 1'b0, 8'h01);
    rd(8'h00, d); chk("R1 zero mask", d, 8'h00);
    rd(8'h14, d); chk("R5 empty header", d, 8'h00);
    chk("R1 no irq", {7'b0, irq}, 8'h00);

    // R2 mask registers: address 4 and address 15
    wr(8'h0C, 8'h10); mask_m[7:0] = 8'h10;
    wr(8'h10, 8'h80); mask_m[15:8] = 8'h80;
    rd(8'h0C, d); chk("R2 mask lo", d, 8'h10);
    rd(8'h10, d); chk("R2 mask hi", d, 8'h80);

    send(8'h04, 1'b1, 8'h36, 4'd3, 1'b0, 8'h10);   // queued
    send(8'h05, 1'b1, 8'h44, 4'd1, 1'b0, 8'h20);   // R1 unclaimed
    rd(8'h00, d); chk("R1 unclaimed not queued", d[6:4], 8'd1);
    send(8'h4F, 1'b0, 8'hAA, 4'd5, 1'b0, 8'h30);   // R6 header only
    send(8'h04, 1'b1, 8'h82, 4'd15, 1'b1, 8'h40);  // R7 error, R11 clamp
    send(8'h0F, 1'b1, 8'h90, 4'd0, 1'b0, 8'h50);
    send(8'h04, 1'b1, 8'h91, 4'd1, 1'b0, 8'h60);   // R3 full, dropped
    rd(8'h00, d); chk("R3 depth saturates", d[6:4], 8'd4);

    // R10 flag set, then cleared by writing 1
    rd(8'h08, d); chk("R10 flag set", d, 8'h02);
    chk("R10 irq high", {7'b0, irq}, 8'h01);
    wr(8'h08, 8'h02);
    rd(8'h08, d); chk("R10 flag cleared", d, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);

    check_head("f1");
    check_head("f3 R6");
    check_head("f4 R7 R11");
    check_head("f5");
    rd(8'h00, d); chk("R3 extra frame absent", d, 8'h00);

    // R8 drop on empty queue has no effect
    wr(8'h04, 8'h01);
    @(negedge clk);
    rd(8'h00, d); chk("R8 drop on empty", d, 8'h00);

    // R9 flush
    send(8'h14, 1'b1, 8'h01, 4'd1, 1'b0, 8'h70);
    send(8'h2F, 1'b1, 8'h02, 4'd2, 1'b0, 8'h80);
    rd(8'h00, d); chk("R9 depth before flush", d[6:4], 8'd2);
    wr(8'h04, 8'h03);
    rd(8'h04, d); chk("R9 flush bits pending", d, 8'h03);
    @(negedge clk);
    sb.delete();
    rd(8'h04, d); chk("R9 flush bits cleared", d, 8'h00);
    rd(8'h00, d); chk("R9 status empty", d, 8'h00);

    // R10 set wins over a same-cycle clear
    wr(8'h08, 8'h02);
    rd(8'h08, d); chk("R10 pre-clear", d, 8'h00);
    @(negedge clk);
    addr = 8'h08; wdata = 8'h02; we = 1'b1;
    drive_frame(8'h34, 1'b1, 8'h55, 4'd1, 1'b0, 8'h90);
    @(negedge clk);
    we = 1'b0; frm_valid = 1'b0;
    rd(8'h08, d); chk("R10 set wins", d, 8'h02);
    check_head("f9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule